// File: doc/BRIEF.md
# Single-Master Shared Bus Controller

This block sequences a minimal single-master system bus. One shared data path is fed, cycle by cycle, by exactly one of three slaves: a program store, a RAM and a small bank of I/O registers. The controller drives it too, when it writes. A memory address register is the only source of the bus address. A control sequencer is the only source of the read and write strobes. An address decoder picks the slave that owns the data path in the current cycle.

Each instruction is started by a pulse on `start_i` together with its fetch address. The fetch read loads the instruction register from the data path. A two-bit operation field in the fetched word then selects one of three follow-on steps. A data read loads the memory data register. A data write drives the memory data register's value onto the path into RAM or I/O. The third choice is no further bus cycle. The data path is modelled inside the chip as a one-hot source multiplexer plus a master output enable, not as tri-state nets. The program store is a behavioural stub whose contents are computed from the address, so every fetch is predictable.

Top module: `sbus_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, `ir_o`, `mdr_o` and `addr_o` are zero, `rd_stb_o`, `wr_stb_o`, `mst_oe_o`, `busy_o` and `done_o` are low, and `drv_sel_o` is zero.
- R2: `start_i` sampled high while idle loads `pc_i` into the address register. The next cycle is a fetch with `rd_stb_o` high and `addr_o` equal to `pc_i`. At its closing edge `ir_o` takes the value on the data path.
- R3: The instruction format is: bits [15:14] are the operation (01 read, 10 write, 00 and 11 none) and bits [11:0] are the target address. After the fetch, the target is loaded into the address register for the data cycle.
- R4: A read operation runs one cycle with `rd_stb_o` high. At its closing edge `mdr_o` takes the value driven by the addressed slave.
- R5: A write operation loads `wr_data_i` into `mdr_o` in the cycle after the fetch. It then runs one cycle with `wr_stb_o` and `mst_oe_o` high, and the addressed RAM or I/O word stores `mdr_o`.
- R6: In every cycle at most one of the bits of `drv_sel_o` (bit 0 program store, bit 1 RAM, bit 2 I/O) and `mst_oe_o` is high. A slave bit is high only while `rd_stb_o` is high, and `mst_oe_o` only while `wr_stb_o` is high.
- R7: The address map is: program store 0x000–0x3FF, RAM 0x400–0x7FF, I/O 0x800–0x80F. All other addresses are unmapped.
- R8: A read of an unmapped address returns 0x0000. A write to one changes no RAM or I/O word.
- R9: A write aimed at the program store changes no RAM or I/O word and leaves the program store contents unchanged.
- R10: With `start_i` sampled at edge k, `done_o` is high for one cycle starting at edge k+2 for a no-op and at k+3 for a read or write. `busy_o` is high from k until `done_o` falls. `start_i` is ignored while busy.
- R11: The program store word at address a (a in 0..1023) is {a[1:0], 2'b00, t}, where t is chosen by a[3:2]: 0 gives 0x400+a[9:2], 1 gives 0x800+a[7:4], 2 gives 0x300+a[9:2], 3 gives 0xF00+a[9:2].
- R12: The I/O registers reset to zero and are then changed only by writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an instruction cycle |
| pc_i | input | 12 | Fetch address for the instruction |
| wr_data_i | input | 16 | Value loaded into the data register for a write |
| busy_o | output | 1 | Instruction cycle in progress |
| done_o | output | 1 | Last cycle of the instruction |
| ir_o | output | 16 | Instruction register |
| mdr_o | output | 16 | Memory data register |
| addr_o | output | 12 | Bus address (address register) |
| rd_stb_o | output | 1 | Read strobe |
| wr_stb_o | output | 1 | Write strobe |
| mst_oe_o | output | 1 | Controller drives the data path |
| drv_sel_o | output | 3 | One-hot slave data-path enable |
| data_o | output | 16 | Current value of the shared data path |

## Verification
Two full passes run every one of the 1024 fetch addresses. Each pass therefore covers every operation code against every target region: RAM, I/O, program store and unmapped. In the second pass each read finds a word written in the first pass, so it separates a correct store from a stale or misrouted one. Writes aimed at the program store and at unmapped addresses are followed by reads of the same and neighbouring words, which shows up any decode that leaks a write. A run that holds `start_i` high with a changing `pc_i` tells a controller that ignores a busy-time start apart from one that restarts. On every cycle the bench checks the single-driver rule and strobe qualification.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_RD, ST_WR, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00, OP_RD = 2'b01, OP_WR = 2'b10, OP_RSV = 2'b11
  } op_e;

  localparam int SRC_PROG = 0;
  localparam int SRC_RAM  = 1;
  localparam int SRC_IO   = 2;
  localparam int NSRC     = 3;
endpackage

// File: rtl/sbus_addr_dec.sv
module sbus_addr_dec #(
  parameter int AW         = 12,
  parameter int PROG_BASE  = 'h000,
  parameter int PROG_WORDS = 1024,
  parameter int RAM_BASE   = 'h400,
  parameter int RAM_WORDS  = 1024,
  parameter int IO_BASE    = 'h800,
  parameter int IO_WORDS   = 16,
  localparam int NSRC      = sbus_pkg::NSRC
) (
  input  logic [AW-1:0]   addr_i,
  input  logic            rd_stb_i,
  input  logic            wr_stb_i,
  output logic [NSRC-1:0] rd_sel_o,
  output logic            ram_we_o,
  output logic            io_we_o
);
  import sbus_pkg::*;

  localparam logic [AW:0] LO [NSRC] = '{
    (AW+1)'(PROG_BASE), (AW+1)'(RAM_BASE), (AW+1)'(IO_BASE)};
  localparam logic [AW:0] HI [NSRC] = '{
    (AW+1)'(PROG_BASE + PROG_WORDS), (AW+1)'(RAM_BASE + RAM_WORDS),
    (AW+1)'(IO_BASE + IO_WORDS)};

  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_hit
    assign hit[i] = ({1'b0, addr_i} >= LO[i]) && ({1'b0, addr_i} < HI[i]);
    assign rd_sel_o[i] = hit[i] & rd_stb_i;
  end

  // program store has no write port: writes there go nowhere
  assign ram_we_o = hit[SRC_RAM] & wr_stb_i;
  assign io_we_o  = hit[SRC_IO]  & wr_stb_i;
endmodule

// File: rtl/sbus_seq.sv
module sbus_seq #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [AW-1:0]         pc_i,
  input  logic [DW-1:0]         wr_data_i,
  input  logic [DW-1:0]         bus_i,
  output sbus_pkg::seq_state_e  state_o,
  output logic [AW-1:0]         mar_o,
  output logic [DW-1:0]         ir_o,
  output logic [DW-1:0]         mdr_o,
  output logic                  rd_stb_o,
  output logic                  wr_stb_o,
  output logic                  mst_oe_o,
  output logic                  busy_o,
  output logic                  done_o
);
  import sbus_pkg::*;

  seq_state_e    state_q;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] ir_q, mdr_q;
  op_e           op;

  assign op = op_e'(ir_q[DW-1:DW-2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mar_q   <= '0;
      ir_q    <= '0;
      mdr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mar_q   <= pc_i;
          state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          ir_q    <= bus_i;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          mar_q <= ir_q[AW-1:0];
          case (op)
            OP_RD:   state_q <= ST_RD;
            OP_WR: begin
              mdr_q   <= wr_data_i;
              state_q <= ST_WR;
            end
            default: state_q <= ST_DONE;
          endcase
        end
        ST_RD: begin
          mdr_q   <= bus_i;
          state_q <= ST_DONE;
        end
        ST_WR:   state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign mar_o    = mar_q;
  assign ir_o     = ir_q;
  assign mdr_o    = mdr_q;
  assign rd_stb_o = (state_q == ST_FETCH) || (state_q == ST_RD);
  assign wr_stb_o = (state_q == ST_WR);
  assign mst_oe_o = (state_q == ST_WR);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
endmodule

// File: rtl/sbus_slaves.sv
module sbus_slaves #(
  parameter int AW         = 12,
  parameter int DW         = 16,
  parameter int PROG_BASE  = 'h000,
  parameter int PROG_WORDS = 1024,
  parameter int RAM_BASE   = 'h400,
  parameter int RAM_WORDS  = 1024,
  parameter int IO_BASE    = 'h800,
  parameter int IO_WORDS   = 16,
  parameter int UNMAP_BASE = 'hF00,
  localparam int PIW       = $clog2(PROG_WORDS),
  localparam int RIW       = $clog2(RAM_WORDS),
  localparam int IIW       = $clog2(IO_WORDS),
  localparam int NSRC      = sbus_pkg::NSRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ram_we_i,
  input  logic          io_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] src_q_o [NSRC]
);
  import sbus_pkg::*;

  localparam int PROG_HI_WIN = PROG_BASE + PROG_WORDS - 2**(PIW-2);

  // behavioural program store: contents are a function of the address
  function automatic logic [DW-1:0] rom_word(input logic [PIW-1:0] a);
    logic [AW-1:0] tgt;
    case (a[3:2])
      2'd0:    tgt = AW'(RAM_BASE)    + AW'(a[PIW-1:2]);
      2'd1:    tgt = AW'(IO_BASE)     + AW'(a[7:4]);
      2'd2:    tgt = AW'(PROG_HI_WIN) + AW'(a[PIW-1:2]);
      default: tgt = AW'(UNMAP_BASE)  + AW'(a[PIW-1:2]);
    endcase
    return {a[1:0], {(DW-2-AW){1'b0}}, tgt};
  endfunction

  logic [DW-1:0] ram_mem [RAM_WORDS];
  logic [DW-1:0] io_q    [IO_WORDS];

  always_ff @(posedge clk_i) begin
    if (ram_we_i) ram_mem[addr_i[RIW-1:0]] <= wdata_i;
  end

  for (genvar i = 0; i < IO_WORDS; i++) begin : g_io
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    io_q[i] <= '0;
      else if (io_we_i && addr_i[IIW-1:0] == IIW'(i)) io_q[i] <= wdata_i;
    end
  end

  assign src_q_o[SRC_PROG] = rom_word(addr_i[PIW-1:0]);
  assign src_q_o[SRC_RAM]  = ram_mem[addr_i[RIW-1:0]];
  assign src_q_o[SRC_IO]   = io_q[addr_i[IIW-1:0]];
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl #(
  parameter int AW         = 12,
  parameter int DW         = 16,
  parameter int PROG_BASE  = 'h000,
  parameter int PROG_WORDS = 1024,
  parameter int RAM_BASE   = 'h400,
  parameter int RAM_WORDS  = 1024,
  parameter int IO_BASE    = 'h800,
  parameter int IO_WORDS   = 16,
  parameter int UNMAP_BASE = 'hF00,
  localparam int NSRC      = sbus_pkg::NSRC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [DW-1:0]   ir_o,
  output logic [DW-1:0]   mdr_o,
  output logic [AW-1:0]   addr_o,
  output logic            rd_stb_o,
  output logic            wr_stb_o,
  output logic            mst_oe_o,
  output logic [NSRC-1:0] drv_sel_o,
  output logic [DW-1:0]   data_o
);
  import sbus_pkg::*;

  seq_state_e    seq_state;
  logic [AW-1:0] mar;
  logic [DW-1:0] mdr, bus_data;
  logic          rd_stb, wr_stb, mst_oe;
  logic [NSRC-1:0] rd_sel;
  logic          ram_we, io_we;
  logic [DW-1:0] src_q [NSRC];

  sbus_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i, .rst_ni, .start_i, .pc_i, .wr_data_i,
    .bus_i    (bus_data),
    .state_o  (seq_state),
    .mar_o    (mar),
    .ir_o     (ir_o),
    .mdr_o    (mdr),
    .rd_stb_o (rd_stb),
    .wr_stb_o (wr_stb),
    .mst_oe_o (mst_oe),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  sbus_addr_dec #(
    .AW(AW), .PROG_BASE(PROG_BASE), .PROG_WORDS(PROG_WORDS),
    .RAM_BASE(RAM_BASE), .RAM_WORDS(RAM_WORDS),
    .IO_BASE(IO_BASE), .IO_WORDS(IO_WORDS)
  ) u_dec (
    .addr_i   (mar),
    .rd_stb_i (rd_stb),
    .wr_stb_i (wr_stb),
    .rd_sel_o (rd_sel),
    .ram_we_o (ram_we),
    .io_we_o  (io_we)
  );

  sbus_slaves #(
    .AW(AW), .DW(DW), .PROG_BASE(PROG_BASE), .PROG_WORDS(PROG_WORDS),
    .RAM_BASE(RAM_BASE), .RAM_WORDS(RAM_WORDS),
    .IO_BASE(IO_BASE), .IO_WORDS(IO_WORDS), .UNMAP_BASE(UNMAP_BASE)
  ) u_slv (
    .clk_i, .rst_ni,
    .addr_i   (mar),
    .ram_we_i (ram_we),
    .io_we_i  (io_we),
    .wdata_i  (bus_data),
    .src_q_o  (src_q)
  );

  // data path: one-hot source OR, controller overrides on write
  always_comb begin
    logic [DW-1:0] slv_or;
    slv_or = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (rd_sel[i]) slv_or = slv_or | src_q[i];
    end
    bus_data = mst_oe ? mdr : slv_or;
  end

  assign mdr_o     = mdr;
  assign addr_o    = mar;
  assign rd_stb_o  = rd_stb;
  assign wr_stb_o  = wr_stb;
  assign mst_oe_o  = mst_oe;
  assign drv_sel_o = rd_sel;
  assign data_o    = bus_data;
endmodule

// File: rtl/sbus_ctrl_chk.sv
module sbus_ctrl_chk #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int RAM_BASE = 'h400
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input sbus_pkg::seq_state_e seq_state,
  input logic [AW-1:0]        addr_o,
  input logic [DW-1:0]        ir_o,
  input logic [DW-1:0]        data_o,
  input logic                 rd_stb_o,
  input logic                 wr_stb_o,
  input logic                 mst_oe_o,
  input logic [2:0]           drv_sel_o,
  input logic                 ram_we,
  input logic                 io_we,
  input logic                 done_o
);
  import sbus_pkg::*;

  // R6
  single_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({drv_sel_o, mst_oe_o}));

  // R6
  sel_needs_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|drv_sel_o) |-> rd_stb_o);

  // R6
  oe_needs_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_oe_o |-> (wr_stb_o && !rd_stb_o));

  // R2
  fetch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_state == ST_FETCH) |=> (ir_o == $past(data_o)));

  // R9
  prog_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && addr_o < AW'(RAM_BASE)) |-> (!ram_we && !io_we));

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && seq_state == ST_IDLE));
endmodule

bind sbus_ctrl sbus_ctrl_chk #(.AW(AW), .DW(DW), .RAM_BASE(RAM_BASE)) u_chk (
  .clk_i, .rst_ni, .seq_state, .addr_o, .ir_o, .data_o, .rd_stb_o,
  .wr_stb_o, .mst_oe_o, .drv_sel_o, .ram_we, .io_we, .done_o
);

// File: tb/sbus_ctrl_tb.sv
module sbus_ctrl_tb;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        start_i = 0;
  logic [11:0] pc_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        busy_o, done_o, rd_stb_o, wr_stb_o, mst_oe_o;
  logic [15:0] ir_o, mdr_o, data_o;
  logic [11:0] addr_o;
  logic [2:0]  drv_sel_o;

  int total = 0;
  int bad   = 0;

  sbus_ctrl u_dut (
    .clk_i, .rst_ni, .start_i, .pc_i, .wr_data_i, .busy_o, .done_o,
    .ir_o, .mdr_o, .addr_o, .rd_stb_o, .wr_stb_o, .mst_oe_o,
    .drv_sel_o, .data_o
  );

  always #2.5 clk_i = ~clk_i;

  logic [15:0] ram_m [1024];
  logic        ram_v [1024];
  logic [15:0] io_m  [16];
  logic [15:0] mdr_exp;
  logic        mdr_known;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // R11 program store contents
  function automatic logic [15:0] word_of(input int a);
    int t;
    case ((a >> 2) & 3)
      0:       t = 'h400 + ((a >> 2) & 'hFF);
      1:       t = 'h800 + ((a >> 4) & 'hF);
      2:       t = 'h300 + ((a >> 2) & 'hFF);
      default: t = 'hF00 + ((a >> 2) & 'hFF);
    endcase
    return 16'(((a & 3) << 14) | t);
  endfunction

  // per-cycle data-path ownership (R6)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk($countones({drv_sel_o, mst_oe_o}) <= 1, "R6 one driver",
          {28'd0, drv_sel_o, mst_oe_o}, 0);
      if (drv_sel_o != 0) chk(rd_stb_o, "R6 sel w/o read", 32'(rd_stb_o), 1);
      if (mst_oe_o) chk(wr_stb_o, "R6 oe w/o write", 32'(wr_stb_o), 1);
    end
  end

  // run one instruction; hold_start keeps start high with a changing pc
  task automatic run(input int pc, input logic [15:0] wd, input bit hold_start);
    logic [15:0] w;
    int op, t, cnt, lat;
    w  = word_of(pc);
    op = w[15:14];
    t  = w[11:0];
    pc_i = 12'(pc); wr_data_i = wd; start_i = 1;
    @(posedge clk_i); cnt = 1;
    @(negedge clk_i);
    chk(rd_stb_o && addr_o == 12'(pc) && busy_o, "R2 fetch cycle", addr_o, pc);
    if (hold_start) pc_i = 12'(pc ^ 'h155); else start_i = 0;
    while (!done_o && cnt < 20) begin
      @(posedge clk_i); cnt++;
      @(negedge clk_i);
      if (cnt == 3 && op == 1)
        chk(rd_stb_o && !wr_stb_o && addr_o == 12'(t), "R3 R4 read cycle", addr_o, t);
      if (cnt == 3 && op == 2)
        chk(wr_stb_o && mst_oe_o && addr_o == 12'(t) && mdr_o == wd,
            "R3 R5 write cycle", mdr_o, wd);
    end
    start_i = 0;
    lat = (op == 1 || op == 2) ? 4 : 3;
    chk(cnt == lat, "R10 latency", cnt, lat);
    chk(ir_o == w, "R2 R11 instruction", ir_o, w);
    // model
    if (op == 2) begin
      mdr_exp = wd; mdr_known = 1;
      if (t >= 'h400 && t < 'h800) begin ram_m[t - 'h400] = wd; ram_v[t - 'h400] = 1; end
      else if (t >= 'h800 && t < 'h810) io_m[t - 'h800] = wd;
    end else if (op == 1) begin
      mdr_known = 1;
      if (t < 'h400) mdr_exp = word_of(t);                                   // R9
      else if (t < 'h800) begin mdr_exp = ram_m[t - 'h400]; mdr_known = ram_v[t - 'h400]; end
      else if (t < 'h810) mdr_exp = io_m[t - 'h800];                         // R12
      else mdr_exp = 16'h0000;                                               // R8
    end
    if (mdr_known) chk(mdr_o == mdr_exp, "R4 R5 R7 R8 mdr", mdr_o, mdr_exp);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R10 back to idle", {busy_o, done_o}, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) ram_v[i] = 0;
    for (int i = 0; i < 16; i++) io_m[i] = '0;
    mdr_exp = '0; mdr_known = 1;
    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk(ir_o == 0 && mdr_o == 0 && addr_o == 0, "R1 regs in reset", ir_o, 0);
    chk(!rd_stb_o && !wr_stb_o && !mst_oe_o && !busy_o && !done_o && drv_sel_o == 0,
        "R1 controls in reset", {rd_stb_o, wr_stb_o, mst_oe_o, busy_o, done_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(!busy_o && ir_o == 0 && mdr_o == 0, "R1 after release", busy_o, 0);
    // two full passes over every fetch address
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 1024; a++)
        run(a, 16'(a * 37 + p * 'h5555 + 1), 0);
    // R10 start held while busy is ignored
    run(1, 16'h1234, 1);
    run(6, 16'hBEEF, 1);
    run(5, 16'h0, 0);
    run(14, 16'hCAFE, 1);
    run(13, 16'h0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule